// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Base ISA

This block is the purely combinational arithmetic stage of a scalar 32-bit integer pipeline. Each cycle the surrounding pipeline presents the decoded opcode, the 3-bit function field and instruction bit 30. It also presents the full instruction word, the two source register values and the program counter of the instruction. The block returns the value to be written to the destination register, together with a write-enable for the register file.

The block covers three groups: the register-immediate operations, the register-register operations, and the two upper-immediate forms (load-upper and add-upper-to-PC). It selects the operation directly from the opcode, the function field and bit 30. It also extracts and sign-extends the immediate, or takes the shift amount from the instruction or from the second operand. Reserved function-field combinations and unknown opcodes produce no write. A write aimed at register zero is suppressed, while the result is still computed.

Top module: `rv_exec_unit`

## Requirements
- R1: Only opcodes 0010011 (register-immediate), 0110011 (register-register), 0110111 (load upper) and 0010111 (add upper to PC) are executed. Any other opcode gives `wr_en_o` = 0 and `result_o` = 0.
- R2: Function field mapping, shared by both forms: 000 add, 010 signed less-than, 011 unsigned less-than, 100 xor, 110 or, 111 and, 001 left shift, 101 right shift.
- R3: The immediate is instruction[31:20], sign-extended from instruction bit 31. This also holds for the unsigned compare, so an immediate of 0xFFF compares against 0xFFFFFFFF.
- R4: The shift amount is instruction[24:20] in immediate form and the low 5 bits of rs2 in register form, and higher rs2 bits are ignored. For a right shift, bit 30 = 0 fills with zeros and bit 30 = 1 copies operand bit 31.
- R5: The less-than forms produce exactly 0 or 1.
- R6: In register form, function field 000 with bit 30 set subtracts rs2 from rs1. Both add and subtract keep the low 32 bits and drop any overflow.
- R7: Load upper gives instruction[31:12] in bits 31:12 with bits 11:0 zero. Add upper to PC gives the PC plus that same value, modulo 2^32.
- R8: The encoding is illegal, giving `wr_en_o` = 0 and `result_o` = 0, in these cases. In immediate form, a left shift needs instruction[31:25] = 0000000, and a right shift needs 0000000 or 0100000. In register form, instruction[31:25] must be 0000000, or 0100000 with function field 000 or 101 only.
- R9: When the destination field instruction[11:7] is 0, `wr_en_o` is 0 while `result_o` still carries the computed value.
- R10: In immediate form, bit 30 is ordinary immediate data for non-shift operations. For example, an add with immediate 0x400 adds 1024 and never subtracts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Opcode field, equal to instruction[6:0] |
| funct3_i | input | 3 | Function field, equal to instruction[14:12] |
| bit30_i | input | 1 | Instruction bit 30 |
| rs1_val_i | input | 32 | First source register value |
| rs2_val_i | input | 32 | Second source register value |
| instr_i | input | 32 | Full instruction word |
| pc_i | input | 32 | Address of the instruction |
| result_o | output | 32 | Value for the destination register |
| wr_en_o | output | 1 | Destination register write-enable |

## Verification
The bench targets the signed and unsigned compare boundaries at 0x80000000 versus 0x7FFFFFFF. A design that mixed up the two compares returns the wrong bit here. It also checks shift amounts of 31 and 0 taken from an rs2 with high bits set. A design that used more than five bits, or filled with the wrong bit, returns a wrong value here. It further targets the add-with-immediate whose bit 30 is set, which a design that decoded subtraction too broadly turns into a subtract. The remaining cases are wrapping add, subtract and PC-relative sums, an all-ones immediate on the unsigned compare, reserved function-field patterns, and writes to register zero. A faulty decoder would write for a reserved pattern, or would write register zero.

// File: rtl/rv_exec_pkg.sv
`timescale 1ns/1ps
package rv_exec_pkg;

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ZERO,
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_SLTU,
    ALU_XOR,
    ALU_OR,
    ALU_AND,
    ALU_SLL,
    ALU_SRL,
    ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCA_ZERO,
    SRCA_RS1,
    SRCA_PC
  } srca_e;

endpackage

// File: rtl/rv_exec_decode.sv
`timescale 1ns/1ps
module rv_exec_decode
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic            bit30_i,
  input  logic [31:7]     ifield_i,
  output alu_op_e         op_o,
  output srca_e           srca_o,
  output logic            use_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic            legal_o,
  output logic            wr_en_o
);

  logic [6:0]  funct7;
  logic [4:0]  rd_idx;
  logic [11:0] imm12;
  logic [19:0] imm20;

  assign funct7 = ifield_i[31:25];
  assign rd_idx = ifield_i[11:7];
  assign imm12  = ifield_i[31:20];
  assign imm20  = ifield_i[31:12];

  function automatic logic [XLEN-1:0] f_sext12(input logic [11:0] v);
    logic [XLEN-1:0] r;
    r = {XLEN{v[11]}};
    r[11:0] = v;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] f_upper(input logic [19:0] v);
    logic [XLEN-1:0] r;
    r = {XLEN{v[19]}};
    r[31:12] = v;
    r[11:0] = 12'h000;
    return r;
  endfunction

  function automatic alu_op_e f_base_op(input logic [2:0] f3, input logic alt,
                                        input logic reg_form);
    alu_op_e o;
    case (f3)
      3'b000:  o = (alt && reg_form) ? ALU_SUB : ALU_ADD;
      3'b010:  o = ALU_SLT;
      3'b011:  o = ALU_SLTU;
      3'b100:  o = ALU_XOR;
      3'b110:  o = ALU_OR;
      3'b111:  o = ALU_AND;
      3'b001:  o = ALU_SLL;
      default: o = alt ? ALU_SRA : ALU_SRL;
    endcase
    return o;
  endfunction

  logic    legal_raw;
  alu_op_e op_raw;

  always_comb begin
    legal_raw = 1'b0;
    op_raw    = ALU_ZERO;
    srca_o    = SRCA_ZERO;
    use_imm_o = 1'b0;
    imm_o     = '0;
    case (opcode_i)
      OPC_IMM: begin
        srca_o    = SRCA_RS1;
        use_imm_o = 1'b1;
        imm_o     = f_sext12(imm12);
        op_raw    = f_base_op(funct3_i, bit30_i, 1'b0);
        case (funct3_i)
          3'b001:  legal_raw = (funct7 == F7_BASE);
          3'b101:  legal_raw = (funct7 == F7_BASE) || (funct7 == F7_ALT);
          default: legal_raw = 1'b1;
        endcase
      end
      OPC_REG: begin
        srca_o = SRCA_RS1;
        op_raw = f_base_op(funct3_i, bit30_i, 1'b1);
        legal_raw = (funct7 == F7_BASE) ||
                    ((funct7 == F7_ALT) && ((funct3_i == 3'b000) || (funct3_i == 3'b101)));
      end
      OPC_LUI: begin
        use_imm_o = 1'b1;
        imm_o     = f_upper(imm20);
        op_raw    = ALU_ADD;
        legal_raw = 1'b1;
      end
      OPC_AUIPC: begin
        srca_o    = SRCA_PC;
        use_imm_o = 1'b1;
        imm_o     = f_upper(imm20);
        op_raw    = ALU_ADD;
        legal_raw = 1'b1;
      end
      default: ;
    endcase
  end

  assign legal_o = legal_raw;
  assign op_o    = legal_raw ? op_raw : ALU_ZERO;
  assign wr_en_o = legal_raw && (rd_idx != 5'd0);

endmodule

// File: rtl/rv_exec_opsel.sv
`timescale 1ns/1ps
module rv_exec_opsel
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  srca_e           srca_i,
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o
);

  always_comb begin
    case (srca_i)
      SRCA_RS1: a_o = rs1_i;
      SRCA_PC:  a_o = pc_i;
      default:  a_o = '0;
    endcase
  end

  assign b_o = use_imm_i ? imm_i : rs2_i;

endmodule

// File: rtl/rv_exec_alu.sv
`timescale 1ns/1ps
module rv_exec_alu
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  localparam int SW = $clog2(XLEN);

  logic [SW-1:0] shamt;
  assign shamt = b_i[SW-1:0];

  function automatic logic f_less(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y,
                                  input logic signed_cmp);
    logic [XLEN-1:0] xs;
    logic [XLEN-1:0] ys;
    xs = x;
    ys = y;
    xs[XLEN-1] = x[XLEN-1] ^ signed_cmp;
    ys[XLEN-1] = y[XLEN-1] ^ signed_cmp;
    return xs < ys;
  endfunction

  function automatic logic [XLEN-1:0] f_shr(input logic [XLEN-1:0] v, input logic [SW-1:0] n,
                                            input logic arith);
    logic [2*XLEN-1:0] wide;
    wide = {{XLEN{arith & v[XLEN-1]}}, v} >> n;
    return wide[XLEN-1:0];
  endfunction

  always_comb begin
    case (op_i)
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, f_less(a_i, b_i, 1'b1)};
      ALU_SLTU: res_o = {{(XLEN-1){1'b0}}, f_less(a_i, b_i, 1'b0)};
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_SLL:  res_o = a_i << shamt;
      ALU_SRL:  res_o = f_shr(a_i, shamt, 1'b0);
      ALU_SRA:  res_o = f_shr(a_i, shamt, 1'b1);
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == ALU_SLT || op_i == ALU_SLTU) begin
      a_r5_compare_is_one_bit: assert (res_o[XLEN-1:1] == '0)
        else $error("compare produced more than one bit");
    end
    if (op_i == ALU_SRA && a_i[XLEN-1]) begin
      a_r4_arith_keeps_sign: assert (res_o[XLEN-1])
        else $error("arithmetic right shift lost the sign");
    end
    if (op_i == ALU_SRL && shamt != '0) begin
      a_r4_logic_fills_zero: assert (!res_o[XLEN-1])
        else $error("logical right shift filled with one");
    end
  end

endmodule

// File: rtl/rv_exec_unit.sv
`timescale 1ns/1ps
module rv_exec_unit
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic            bit30_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o
);

  alu_op_e         op;
  srca_e           srca;
  logic            use_imm;
  logic [XLEN-1:0] imm;
  logic            legal;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;

  rv_exec_decode #(.XLEN(XLEN)) u_dec (
    .opcode_i  (opcode_i),
    .funct3_i  (funct3_i),
    .bit30_i   (bit30_i),
    .ifield_i  (instr_i[31:7]),
    .op_o      (op),
    .srca_o    (srca),
    .use_imm_o (use_imm),
    .imm_o     (imm),
    .legal_o   (legal),
    .wr_en_o   (wr_en_o)
  );

  rv_exec_opsel #(.XLEN(XLEN)) u_sel (
    .srca_i    (srca),
    .use_imm_i (use_imm),
    .rs1_i     (rs1_val_i),
    .rs2_i     (rs2_val_i),
    .pc_i      (pc_i),
    .imm_i     (imm),
    .a_o       (opa),
    .b_o       (opb)
  );

  rv_exec_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (op),
    .a_i   (opa),
    .b_i   (opb),
    .res_o (result_o)
  );

  logic known_opc;
  assign known_opc = (opcode_i == OPC_IMM) || (opcode_i == OPC_REG) ||
                     (opcode_i == OPC_LUI) || (opcode_i == OPC_AUIPC);

  always_comb begin
    a_r1_opcode_field_agrees: assert (instr_i[6:0] == opcode_i)
      else $error("opcode input disagrees with instruction word");
    if (!known_opc) begin
      a_r1_unknown_is_quiet: assert (!wr_en_o && result_o == '0)
        else $error("unknown opcode produced activity");
    end
    if (!legal) begin
      a_r8_illegal_is_quiet: assert (!wr_en_o && result_o == '0)
        else $error("illegal encoding produced activity");
    end
    if (wr_en_o) begin
      a_r9_no_zero_dest_write: assert (instr_i[11:7] != 5'd0)
        else $error("write enabled for register zero");
    end
    if (opcode_i == OPC_LUI) begin
      a_r7_upper_low_bits_zero: assert (result_o[11:0] == 12'h000)
        else $error("load upper left low bits set");
    end
  end

endmodule

// File: tb/tb_rv_exec_unit.sv
`timescale 1ns/1ps
module tb_rv_exec_unit;

  localparam int  NV          = 38;
  localparam int  NRAND       = 400;
  localparam time WATCHDOG_NS = 100000;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] pc;
    logic [31:0] exp;
    logic        we;
  } vec_t;

  localparam logic [31:0] PCD = 32'h0000_1000;

  localparam vec_t VEC [NV] = '{
    '{4'd2,  32'h00560693, 32'h00000010, 32'h0,        PCD,          32'h00000015, 1'b1}, // R2 addi
    '{4'd3,  32'hFFF60693, 32'h00000010, 32'h0,        PCD,          32'h0000000F, 1'b1}, // R3 addi -1
    '{4'd10, 32'h40060693, 32'h00000001, 32'h0,        PCD,          32'h00000401, 1'b1}, // R10 bit30 is data
    '{4'd5,  32'h00562693, 32'hFFFFFFFF, 32'h0,        PCD,          32'h00000001, 1'b1}, // R5 slti true
    '{4'd5,  32'h00562693, 32'h00000005, 32'h0,        PCD,          32'h00000000, 1'b1}, // R5 slti equal
    '{4'd3,  32'hFFF63693, 32'h12345678, 32'h0,        PCD,          32'h00000001, 1'b1}, // R3 sltiu vs all ones
    '{4'd3,  32'hFFF63693, 32'hFFFFFFFF, 32'h0,        PCD,          32'h00000000, 1'b1}, // R3 sltiu equal
    '{4'd2,  32'hFFF64693, 32'h0F0F0F0F, 32'h0,        PCD,          32'hF0F0F0F0, 1'b1}, // R2 xori invert
    '{4'd3,  32'h80066693, 32'h00000001, 32'h0,        PCD,          32'hFFFFF801, 1'b1}, // R3 ori negative
    '{4'd2,  32'h7FF67693, 32'hFFFFFFFF, 32'h0,        PCD,          32'h000007FF, 1'b1}, // R2 andi
    '{4'd4,  32'h00361693, 32'h80000001, 32'h0,        PCD,          32'h00000008, 1'b1}, // R4 slli 3
    '{4'd4,  32'h01F65693, 32'h80000000, 32'h0,        PCD,          32'h00000001, 1'b1}, // R4 srli 31
    '{4'd4,  32'h41F65693, 32'h80000000, 32'h0,        PCD,          32'hFFFFFFFF, 1'b1}, // R4 srai 31
    '{4'd4,  32'h40465693, 32'h7FFFFFF0, 32'h0,        PCD,          32'h07FFFFFF, 1'b1}, // R4 srai positive
    '{4'd6,  32'h00D60733, 32'h7FFFFFFF, 32'h00000001, PCD,          32'h80000000, 1'b1}, // R6 add overflow
    '{4'd6,  32'h00D60733, 32'hFFFFFFFF, 32'h00000002, PCD,          32'h00000001, 1'b1}, // R6 add wrap
    '{4'd6,  32'h40D60733, 32'h00000000, 32'h00000001, PCD,          32'hFFFFFFFF, 1'b1}, // R6 sub borrow
    '{4'd6,  32'h40D60733, 32'h80000000, 32'h00000001, PCD,          32'h7FFFFFFF, 1'b1}, // R6 sub overflow
    '{4'd5,  32'h00D62733, 32'h80000000, 32'h7FFFFFFF, PCD,          32'h00000001, 1'b1}, // R5 slt boundary
    '{4'd5,  32'h00D63733, 32'h80000000, 32'h7FFFFFFF, PCD,          32'h00000000, 1'b1}, // R5 sltu boundary
    '{4'd2,  32'h00D64733, 32'hFF00FF00, 32'h0FF00FF0, PCD,          32'hF0F0F0F0, 1'b1}, // R2 xor
    '{4'd2,  32'h00D66733, 32'h000000A0, 32'h00000005, PCD,          32'h000000A5, 1'b1}, // R2 or
    '{4'd2,  32'h00D67733, 32'h0000F0F0, 32'h0000FF00, PCD,          32'h0000F000, 1'b1}, // R2 and
    '{4'd4,  32'h00D61733, 32'h00000001, 32'hFFFFFFE4, PCD,          32'h00000010, 1'b1}, // R4 sll high bits ignored
    '{4'd4,  32'h00D65733, 32'h80000000, 32'h0000003F, PCD,          32'h00000001, 1'b1}, // R4 srl 31
    '{4'd4,  32'h40D65733, 32'h80000000, 32'h0000001F, PCD,          32'hFFFFFFFF, 1'b1}, // R4 sra 31
    '{4'd4,  32'h40D65733, 32'h80000000, 32'h00000020, PCD,          32'h80000000, 1'b1}, // R4 sra amount 0
    '{4'd7,  32'hF0000437, 32'h12345678, 32'h9ABCDEF0, PCD,          32'hF0000000, 1'b1}, // R7 lui
    '{4'd7,  32'h00F00617, 32'h12345678, 32'h0,        32'h00001000, 32'h00F01000, 1'b1}, // R7 auipc
    '{4'd7,  32'hFFFFF617, 32'h0,        32'h0,        32'h00002000, 32'h00001000, 1'b1}, // R7 auipc wrap
    '{4'd1,  32'h00000000, 32'h11111111, 32'h22222222, PCD,          32'h00000000, 1'b0}, // R1 opcode zero
    '{4'd1,  32'h00D60063, 32'h11111111, 32'h22222222, PCD,          32'h00000000, 1'b0}, // R1 branch opcode
    '{4'd8,  32'h40361693, 32'h00000001, 32'h0,        PCD,          32'h00000000, 1'b0}, // R8 slli alt funct7
    '{4'd8,  32'h42365693, 32'h80000000, 32'h0,        PCD,          32'h00000000, 1'b0}, // R8 srai stray bit
    '{4'd8,  32'h40D64733, 32'h00000003, 32'h00000005, PCD,          32'h00000000, 1'b0}, // R8 xor alt funct7
    '{4'd8,  32'h02D60733, 32'h00000003, 32'h00000005, PCD,          32'h00000000, 1'b0}, // R8 add funct7 01
    '{4'd9,  32'h00560013, 32'h00000000, 32'h0,        PCD,          32'h00000005, 1'b0}, // R9 addi to x0
    '{4'd9,  32'h00D60033, 32'h00000003, 32'h00000004, PCD,          32'h00000007, 1'b0}  // R9 add to x0
  };

  logic        clk;
  logic        rst_n;
  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic        bit30;
  logic [31:0] rs1_val;
  logic [31:0] rs2_val;
  logic [31:0] instr;
  logic [31:0] pc;
  logic [31:0] result;
  logic        wr_en;

  int checks;
  int fails;
  bit done;

  rv_exec_unit #(.XLEN(32)) dut (
    .opcode_i  (opcode),
    .funct3_i  (funct3),
    .bit30_i   (bit30),
    .rs1_val_i (rs1_val),
    .rs2_val_i (rs2_val),
    .instr_i   (instr),
    .pc_i      (pc),
    .result_o  (result),
    .wr_en_o   (wr_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] p);
    @(posedge clk);
    instr   <= w;
    opcode  <= w[6:0];
    funct3  <= w[14:12];
    bit30   <= w[30];
    rs1_val <= a;
    rs2_val <= b;
    pc      <= p;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [31:0] exp_res, input logic exp_we);
    checks++;
    if (result !== exp_res || wr_en !== exp_we) begin
      fails++;
      $display("FAIL R%0d instr=%08h: result=%08h we=%0b, expected result=%08h we=%0b",
               req, instr, result, wr_en, exp_res, exp_we);
    end
  endtask

  // Independent model of the register-immediate and register-register forms
  function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] y;
    logic [31:0] r;
    int          n;
    y = (w[6:0] == 7'b0010011) ? {{20{w[31]}}, w[31:20]} : b;
    n = int'(y[4:0]);
    case (w[14:12])
      3'b000: r = (w[6:0] == 7'b0110011 && w[30]) ? a + ~y + 32'd1 : a + y;
      3'b010: r = {31'd0, $signed(a) < $signed(y)};
      3'b011: r = {31'd0, a < y};
      3'b100: r = a ^ y;
      3'b110: r = a | y;
      3'b111: r = a & y;
      3'b001: begin
        r = a;
        for (int k = 0; k < n; k++) r = {r[30:0], 1'b0};
      end
      default: begin
        r = a;
        for (int k = 0; k < n; k++) r = {w[30] & a[31], r[31:1]};
      end
    endcase
    return r;
  endfunction

  function automatic logic [31:0] corner(input int sel);
    case (sel % 5)
      0:       return 32'h80000000;
      1:       return 32'h7FFFFFFF;
      2:       return 32'h00000000;
      3:       return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    instr   = '0;
    opcode  = '0;
    funct3  = '0;
    bit30   = 1'b0;
    rs1_val = '0;
    rs2_val = '0;
    pc      = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle all-zero inputs carry an unknown opcode, so nothing is written
    check(1, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].instr, VEC[i].a, VEC[i].b, VEC[i].pc);
      check(int'(VEC[i].req), VEC[i].exp, VEC[i].we);
    end

    // R2 R4 R5 R6: random legal encodings over corner and random operands
    for (int i = 0; i < NRAND; i++) begin
      logic [31:0] w;
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  f3;
      logic [4:0]  rd;
      logic [11:0] im;
      logic        alt;
      f3  = 3'($urandom);
      rd  = 5'(1 + ($urandom % 31));
      alt = 1'($urandom);
      a   = corner(i + int'($urandom % 5));
      b   = corner(i / 5 + int'($urandom % 5));
      if (i % 8 == 7) b[4:0] = 5'd31;
      if (i % 2 == 0) begin
        im = 12'($urandom);
        if (i % 8 == 6) im[4:0] = 5'd31;
        if (f3 == 3'b001) im[11:5] = 7'b0000000;
        if (f3 == 3'b101) im[11:5] = alt ? 7'b0100000 : 7'b0000000;
        w = {im, 5'd12, f3, rd, 7'b0010011};
      end else begin
        w = {((f3 == 3'b000 || f3 == 3'b101) && alt) ? 7'b0100000 : 7'b0000000,
             5'd13, 5'd12, f3, rd, 7'b0110011};
      end
      drive(w, a, b, PCD);
      check(2, model(w, a, b), 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule